// File: doc/BRIEF.md
# LFSR-Sequenced Accumulator Processor Core

A small 16-bit accumulator processor whose program counter is an 8-bit linear feedback shift register. The core has no adder anywhere. The next instruction address is one shift-and-XOR step of the current one. The operations are XOR, AND, single-bit shifts, load, store, jump and jump-if-zero. Each instruction carries a 12-bit literal. A flag bit turns that literal into a pointer, so the operand is read from memory first.

The core drives one single-port synchronous memory. Read data returns one cycle after the address is presented. Any data access to an address whose top bit is set becomes a byte transfer on the I/O handshake instead of a memory access:
- A read waits for an input-available flag.
- A write waits while an output-busy flag is high.
- A pause input freezes the core before it starts the next instruction.

Top module: `lfsr_acc_cpu`

## Requirements
- R1: While rst_ni is low the core presents address 0, write enable low, and both I/O strobes low. After reset, execution begins at address 0 with the accumulator at 0.
- R2: An instruction word has three fields. Bit 15 is the indirect flag, bits 14..12 are the opcode, and bits 11..0 are the operand. With the flag clear, the argument is the operand zero-extended to 16 bits. With the flag set, the argument is the memory word at the operand address.
- R3: Opcode 0 sets acc to acc XOR arg. Opcode 1 sets acc to acc AND arg. Opcode 2 sets acc to arg shifted left by one. Opcode 3 sets acc to arg shifted right by one, filling with zero.
- R4: Opcode 4 loads acc from memory at address arg. Opcode 5 writes acc to memory at address arg with a single-cycle write enable.
- R5: Opcode 6 sets the program counter to arg[7:0]. Opcode 7 does the same only when acc is zero, and otherwise advances normally.
- R6: Every other instruction advances the program counter by one Galois step: next = (pc >> 1) XOR (pc[0] ? 8'hB8 : 0).
- R7: Address 0 is a fixed point of the step. An instruction at address 0 that is not a jump executes again forever.
- R8: The cycles per instruction are fixed:
  - direct ALU and jump: 1
  - indirect ALU and jump: 2
  - direct load and store: 3
  - indirect load and store: 4
- R9: While pause_i is high the core begins no new instruction, and no results change.
- R10: A load whose address has bit 15 set waits until in_valid_i is high. It then places {8'h00, in_data_i} in acc and pulses in_ack_o for one cycle.
- R11: A store whose address has bit 15 set does not write memory. It waits while out_busy_i is high, then pulses out_valid_o for one cycle with out_data_o equal to acc[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Word address presented to memory, sampled at the clock edge |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the address |
| pause_i | input | 1 | Hold before the next instruction |
| in_valid_i | input | 1 | Input byte available |
| in_data_i | input | 8 | Input byte |
| in_ack_o | output | 1 | Input byte consumed |
| out_busy_i | input | 1 | Output side cannot accept a byte |
| out_valid_o | output | 1 | Output byte strobe |
| out_data_o | output | 8 | Output byte |

## Verification
The exact cycle count of each instruction class is the property hardest to observe from the ports. It is visible only as the spacing between memory writes. Random programs are therefore laid out along the shift-register address sequence with frequent stores. A bench interpreter predicts each write's address, data and cycle offset, and the write-to-write gaps are compared. The I/O stalls and the taken or not-taken jump-if-zero are reached through a directed program. That program uses pointer cells holding addresses with bit 15 set, with the handshake inputs held off for many cycles.

// File: rtl/lfsr_cpu_pkg.sv
package lfsr_cpu_pkg;
  localparam int WORD_W = 16;
  localparam int OPER_W = 12;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_XOR   = 3'd0,
    OP_AND   = 3'd1,
    OP_LSL   = 3'd2,
    OP_LSR   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_JMP   = 3'd6,
    OP_JMPZ  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_IND,
    ST_LOAD,
    ST_STORE,
    ST_NEXT
  } state_e;

  typedef struct packed {
    logic              ind;
    op_e               op;
    logic [OPER_W-1:0] oper;
  } instr_t;
endpackage

// File: rtl/lfsr_cpu_pc.sv
module lfsr_cpu_pc #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   MASK = 8'hB8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] step_o
);
  logic [W-1:0] pc_q;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign step_o[i] = MASK[i] & pc_q[0];
    end else begin : g_mid
      assign step_o[i] = pc_q[i+1] ^ (MASK[i] & pc_q[0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (load_i) pc_q <= load_val_i;
    else if (adv_i)  pc_q <= step_o;
  end

  assign pc_o = pc_q;

  p_zero_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q == '0 && adv_i && !load_i) |=> (pc_q == '0));

  p_no_lockup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != '0 && adv_i && !load_i) |=> (pc_q != '0));
endmodule

// File: rtl/lfsr_cpu_alu.sv
module lfsr_cpu_alu
  import lfsr_cpu_pkg::*;
(
  input  op_e               op_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] arg_i,
  output logic [WORD_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_XOR:  res_o = acc_i ^ arg_i;
      OP_AND:  res_o = acc_i & arg_i;
      OP_LSL:  res_o = {arg_i[WORD_W-2:0], 1'b0};
      OP_LSR:  res_o = {1'b0, arg_i[WORD_W-1:1]};
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/lfsr_acc_cpu.sv
module lfsr_acc_cpu
  import lfsr_cpu_pkg::*;
#(
  parameter int                PC_W    = 8,
  parameter logic [PC_W-1:0]   PC_MASK = 8'hB8,
  parameter int                ADDR_W  = 12,
  parameter int                BYTE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              pause_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ack_o,
  input  logic              out_busy_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o
);
  localparam int IO_BIT = WORD_W - 1;

  state_e            st_q, st_d;
  logic [WORD_W-1:0] acc_q, acc_d, arg_q, arg_d;
  instr_t            ir_q, ir_d, fetch_ir;

  logic [PC_W-1:0]   pc, pc_step;
  logic              pc_adv, pc_ld;

  logic              exec_go;
  op_e               exec_op;
  logic [WORD_W-1:0] exec_arg, alu_res;

  assign fetch_ir = instr_t'(mem_rdata_i);

  lfsr_cpu_pc #(.W(PC_W), .MASK(PC_MASK)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (pc_adv),
    .load_i     (pc_ld),
    .load_val_i (exec_arg[PC_W-1:0]),
    .pc_o       (pc),
    .step_o     (pc_step)
  );

  lfsr_cpu_alu u_alu (
    .op_i  (exec_op),
    .acc_i (acc_q),
    .arg_i (exec_arg),
    .res_o (alu_res)
  );

  always_comb begin
    st_d        = st_q;
    acc_d       = acc_q;
    arg_d       = arg_q;
    ir_d        = ir_q;
    pc_adv      = 1'b0;
    pc_ld       = 1'b0;
    mem_addr_o  = {{(ADDR_W-PC_W){1'b0}}, pc};
    mem_we_o    = 1'b0;
    in_ack_o    = 1'b0;
    out_valid_o = 1'b0;
    exec_go     = 1'b0;
    exec_op     = OP_XOR;
    exec_arg    = '0;

    unique case (st_q)
      ST_FETCH: begin
        if (!pause_i) begin
          ir_d = fetch_ir;
          if (fetch_ir.ind) begin
            mem_addr_o = fetch_ir.oper[ADDR_W-1:0];
            st_d       = ST_IND;
          end else begin
            exec_go  = 1'b1;
            exec_op  = fetch_ir.op;
            exec_arg = {{(WORD_W-OPER_W){1'b0}}, fetch_ir.oper};
          end
        end
      end
      ST_IND: begin
        exec_go  = 1'b1;
        exec_op  = ir_q.op;
        exec_arg = mem_rdata_i;
      end
      ST_LOAD: begin
        mem_addr_o = arg_q[ADDR_W-1:0];
        if (arg_q[IO_BIT]) begin
          if (in_valid_i) begin
            acc_d    = {{(WORD_W-BYTE_W){1'b0}}, in_data_i};
            in_ack_o = 1'b1;
            pc_adv   = 1'b1;
            st_d     = ST_NEXT;
          end
        end else begin
          acc_d  = mem_rdata_i;
          pc_adv = 1'b1;
          st_d   = ST_NEXT;
        end
      end
      ST_STORE: begin
        mem_addr_o = arg_q[ADDR_W-1:0];
        if (arg_q[IO_BIT]) begin
          if (!out_busy_i) begin
            out_valid_o = 1'b1;
            pc_adv      = 1'b1;
            st_d        = ST_NEXT;
          end
        end else begin
          mem_we_o = 1'b1;
          pc_adv   = 1'b1;
          st_d     = ST_NEXT;
        end
      end
      default: st_d = ST_FETCH;
    endcase

    if (exec_go) begin
      arg_d = exec_arg;
      unique case (exec_op)
        OP_LOAD: begin
          mem_addr_o = exec_arg[ADDR_W-1:0];
          st_d       = ST_LOAD;
        end
        OP_STORE: st_d = ST_STORE;
        OP_JMP: begin
          pc_ld      = 1'b1;
          mem_addr_o = {{(ADDR_W-PC_W){1'b0}}, exec_arg[PC_W-1:0]};
          st_d       = ST_FETCH;
        end
        OP_JMPZ: begin
          st_d = ST_FETCH;
          if (acc_q == '0) begin
            pc_ld      = 1'b1;
            mem_addr_o = {{(ADDR_W-PC_W){1'b0}}, exec_arg[PC_W-1:0]};
          end else begin
            pc_adv     = 1'b1;
            mem_addr_o = {{(ADDR_W-PC_W){1'b0}}, pc_step};
          end
        end
        default: begin
          acc_d      = alu_res;
          pc_adv     = 1'b1;
          mem_addr_o = {{(ADDR_W-PC_W){1'b0}}, pc_step};
          st_d       = ST_FETCH;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_NEXT;
      acc_q <= '0;
      arg_q <= '0;
      ir_q  <= '0;
    end else begin
      st_q  <= st_d;
      acc_q <= acc_d;
      arg_q <= arg_d;
      ir_q  <= ir_d;
    end
  end

  assign mem_wdata_o = acc_q;
  assign out_data_o  = acc_q[BYTE_W-1:0];

  p_ack_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |-> in_valid_i);

  p_ack_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |=> !in_ack_o);

  p_out_not_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !out_busy_i);

  p_out_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  p_io_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !mem_we_o);

  p_pause_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH && pause_i) |=> (st_q == ST_FETCH && $stable(acc_q) && $stable(pc)));

  p_write_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_next_to_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NEXT) |=> (st_q == ST_FETCH));
endmodule

// File: tb/lfsr_acc_cpu_tb_top.sv
module lfsr_acc_cpu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] mem_addr_o;
  logic        mem_we_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic        pause_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ack_o;
  logic        out_busy_i = 1'b0;
  logic        out_valid_o;
  logic [7:0]  out_data_o;

  lfsr_acc_cpu dut_i (
    .clk_i, .rst_ni, .mem_addr_o, .mem_we_o, .mem_wdata_o, .mem_rdata_i,
    .pause_i, .in_valid_i, .in_data_i, .in_ack_o, .out_busy_i,
    .out_valid_o, .out_data_o
  );

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int total = 0;
  bit pause_en = 1'b0;

  logic [15:0] mem  [1024];
  logic [15:0] prog [1024];
  logic [15:0] mm   [1024];
  logic [15:0] rd_next = '0;

  logic [11:0] wl_addr [512];
  logic [15:0] wl_data [512];
  int          wl_cyc  [512];
  int          wl_n = 0;
  logic [11:0] ex_addr [512];
  logic [15:0] ex_data [512];
  int          ex_cyc  [512];
  int          ex_n = 0;
  int          ack_n = 0;
  int          oval_n = 0;
  logic [7:0]  odata = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lstep(input logic [7:0] p);
    return (p >> 1) ^ (p[0] ? 8'hB8 : 8'h00);
  endfunction

  always @(posedge clk_i) begin
    cyc   <= cyc + 1;
    total <= total + 1;
    mem_rdata_i <= rd_next;
    if (total > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", total, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_we_o) begin
        mem[mem_addr_o[9:0]] = mem_wdata_o;
        if (wl_n < 512) begin
          wl_addr[wl_n] = mem_addr_o;
          wl_data[wl_n] = mem_wdata_o;
          wl_cyc[wl_n]  = cyc;
          wl_n++;
        end
      end
      if (in_ack_o) ack_n++;
      if (out_valid_o) begin
        oval_n++;
        odata = out_data_o;
      end
    end
    rd_next = mem[mem_addr_o[9:0]];
  end

  initial forever begin
    @(posedge clk_i);
    #1 pause_i = pause_en && (($urandom % 3) == 0);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk_i);
    #1 rst_ni = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = prog[i];
    wl_n = 0; ack_n = 0; oval_n = 0;
    repeat (3) begin
      @(negedge clk_i);
      chk(mem_addr_o == 12'h000 && !mem_we_o && !out_valid_o && !in_ack_o,
          "R1 reset outputs", {mem_we_o, out_valid_o, in_ack_o, mem_addr_o}, 0);
    end
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  function automatic logic [15:0] rand_instr(input logic [7:0] a);
    int r;
    logic ind;
    logic [2:0] op;
    logic [11:0] opr;
    r   = int'($urandom % 10);
    ind = 1'($urandom % 2);
    case (r)
      0, 1, 2, 3: begin
        op  = 3'(r);
        opr = ind ? 12'(12'h100 + ($urandom % 128)) : 12'($urandom);
      end
      4: begin
        op  = 3'd4;
        opr = ind ? 12'(12'h180 + ($urandom % 16)) : 12'(12'h100 + ($urandom % 256));
      end
      6: begin op = 3'd6; ind = 1'b0; opr = {4'h0, lstep(a)}; end
      7: begin op = 3'd7; ind = 1'b0; opr = {4'h0, lstep(a)}; end
      default: begin
        op  = 3'd5;
        opr = ind ? 12'(12'h180 + ($urandom % 16)) : 12'(12'h200 + ($urandom % 256));
      end
    endcase
    return {ind, op, opr};
  endfunction

  task automatic build_random();
    logic [7:0] a;
    for (int i = 0; i < 1024; i++) prog[i] = '0;
    prog[0] = 16'h6001;
    for (int i = 0; i < 128; i++) prog[256+i] = 16'($urandom);
    for (int i = 0; i < 16; i++) prog[12'h180+i] = 16'(16'h0200 + i * 16);
    a = 8'h01;
    for (int k = 0; k < 180; k++) begin
      prog[a] = rand_instr(a);
      a = lstep(a);
    end
    prog[a] = 16'h6000 | {8'h00, a};
  endtask

  task automatic model_run();
    logic [15:0] macc, arg, ins;
    logic [7:0]  mpc, npc;
    logic [2:0]  op;
    logic        ind;
    int          t;
    for (int i = 0; i < 1024; i++) mm[i] = prog[i];
    macc = '0; mpc = '0; t = 0; ex_n = 0;
    for (int s = 0; s < 2000; s++) begin
      ins = mm[{2'b00, mpc}];
      ind = ins[15];
      op  = ins[14:12];
      if (!ind && op == 3'd6 && ins[7:0] == mpc) break;
      arg = ind ? mm[ins[9:0]] : {4'h0, ins[11:0]};
      npc = lstep(mpc);
      case (op)
        3'd0: macc = macc ^ arg;
        3'd1: macc = macc & arg;
        3'd2: macc = arg << 1;
        3'd3: macc = arg >> 1;
        3'd4: macc = mm[arg[9:0]];
        3'd5: begin
          mm[arg[9:0]] = macc;
          ex_addr[ex_n] = arg[11:0];
          ex_data[ex_n] = macc;
          ex_cyc[ex_n]  = t + (ind ? 2 : 1);
          ex_n++;
        end
        3'd6: npc = arg[7:0];
        default: if (macc == 16'h0) npc = arg[7:0];
      endcase
      t  += ((op == 3'd4 || op == 3'd5) ? 3 : 1) + (ind ? 1 : 0);
      mpc = npc;
    end
  endtask

  task automatic compare(input bit timing);
    int n;
    chk(wl_n == ex_n, "R4 write count", wl_n, ex_n);
    n = (wl_n < ex_n) ? wl_n : ex_n;
    for (int i = 0; i < n; i++) begin
      chk(wl_addr[i] == ex_addr[i], "R4 R2 write address", int'(wl_addr[i]), int'(ex_addr[i]));
      chk(wl_data[i] == ex_data[i], "R3 R2 write data", int'(wl_data[i]), int'(ex_data[i]));
      if (timing && i > 0)
        chk(wl_cyc[i] - wl_cyc[i-1] == ex_cyc[i] - ex_cyc[i-1], "R8 write spacing",
            wl_cyc[i] - wl_cyc[i-1], ex_cyc[i] - ex_cyc[i-1]);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 1024; i++) begin prog[i] = '0; mem[i] = '0; end

    // R7 R1: store at address 0 repeats forever, accumulator starts at zero
    prog[0] = 16'h5200;
    do_reset();
    wait_cyc(24);
    chk(wl_n >= 5, "R7 repeat count", wl_n, 5);
    for (int i = 0; i < 5 && i < wl_n; i++) begin
      chk(wl_addr[i] == 12'h200, "R7 repeat address", int'(wl_addr[i]), 12'h200);
      chk(wl_data[i] == 16'h0, "R1 acc reset value", int'(wl_data[i]), 0);
      if (i > 0) chk(wl_cyc[i] - wl_cyc[i-1] == 3, "R8 direct store cycles",
                     wl_cyc[i] - wl_cyc[i-1], 3);
    end

    // R6 R2 R3 R4 R5 R8: random program along the shift-register sequence
    for (int rep = 0; rep < 3; rep++) begin
      build_random();
      model_run();
      do_reset();
      wait_cyc(1500);
      compare(1'b1);
    end

    // R9: same program with pause toggling; results must be unchanged
    model_run();
    pause_en = 1'b1;
    do_reset();
    wait_cyc(4000);
    pause_en = 1'b0;
    compare(1'b0);

    // R10 R11 R5: I/O stalls and jump-if-zero
    for (int i = 0; i < 1024; i++) prog[i] = '0;
    prog[12'h000] = 16'h6001;
    prog[12'h001] = 16'hC190;  // indirect load through pointer to I/O
    prog[12'h0B8] = 16'hD190;  // indirect store through pointer to I/O
    prog[12'h05C] = 16'h5210;
    prog[12'h02E] = 16'h7040;  // jump-if-zero, not taken
    prog[12'h017] = 16'h1000;  // AND #0
    prog[12'h0B3] = 16'hF191;  // indirect jump-if-zero, taken
    prog[12'h0E1] = 16'h52EE;
    prog[12'h0C8] = 16'h60C8;
    prog[12'h040] = 16'h52EE;
    prog[12'h090] = 16'h5211;
    prog[12'h048] = 16'h6048;
    prog[12'h190] = 16'h8000;
    prog[12'h191] = 16'h0090;
    in_valid_i = 1'b0;
    out_busy_i = 1'b1;
    do_reset();
    wait_cyc(12);
    chk(ack_n == 0, "R10 input stall", ack_n, 0);
    in_data_i  = 8'h5A;
    in_valid_i = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (in_ack_o) break;
    end
    @(posedge clk_i);
    #1 in_valid_i = 1'b0;
    wait_cyc(30);
    chk(oval_n == 0, "R11 output stall", oval_n, 0);
    chk(wl_n == 0, "R11 no memory write for I/O", wl_n, 0);
    out_busy_i = 1'b0;
    wait_cyc(30);
    chk(ack_n == 1, "R10 ack pulses", ack_n, 1);
    chk(oval_n == 1, "R11 output pulses", oval_n, 1);
    chk(odata == 8'h5A, "R11 output byte", int'(odata), 8'h5A);
    chk(wl_n == 2, "R5 jump-if-zero path writes", wl_n, 2);
    if (wl_n >= 2) begin
      chk(wl_addr[0] == 12'h210 && wl_data[0] == 16'h005A, "R10 byte zero-extended",
          int'(wl_data[0]), 16'h005A);
      chk(wl_addr[1] == 12'h211 && wl_data[1] == 16'h0000, "R5 taken target",
          int'(wl_addr[1]), 12'h211);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule